// File: doc/BRIEF.md
# Multi-Level Daisy-Chain Bus Arbiter

This block is a central bus arbiter that serves several priority tiers of bus requesters. Each tier shares one request line and one grant line. The tier's request line is the OR of the pending requests of every device on that tier. Its grant line enters the first device of the tier and travels device to device. A device with a pending request absorbs the grant. A device without one forwards the grant to its neighbour.

Priority is therefore resolved in two steps. The arbiter first picks the most important tier that is requesting. The grant then stops at the first requesting device on that tier's chain, counted from the arbiter end.

The per-device chain cells are modelled in the same synthesizable block as the central picker. A host pulses a device's request input to queue a request. When that device wins, it becomes bus master and drives bus-busy. It keeps the bus until its done input is pulsed. A new grant is issued only while the bus is idle, so a master is never displaced.

Top module: `prio_chain_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tier_grant`, `dev_master` and `bus_busy` are all zero.
- R2: A one-cycle request on `dev_req` sampled at edge k on an idle bus raises the tier's `tier_grant` bit after edge k+1, and raises the device's `dev_master` bit and `bus_busy` after edge k+2. Device d of tier t uses bit t*N_DEV+d of every per-device vector.
- R3: With the default PRIO_DIR (lowest index first), the arbiter grants the lowest-numbered tier that has a pending request. Tier t uses bit t of `tier_grant`.
- R4: Within the granted tier, the pending device with the lowest index, which is nearest the arbiter on the chain, takes the bus.
- R5: At most one bit of `tier_grant` is high at a time. A grant lasts exactly one cycle and is followed by exactly one master.
- R6: While `bus_busy` is high, no tier grant is issued and the current master stays unchanged until its own done pulse.
- R7: The master's pending request is cleared when it takes the bus. A done pulse from the master clears `dev_master` and `bus_busy` on the next edge.
- R8: A request from the device that is currently master is ignored. A done pulse from a device that is not master is ignored.
- R9: A request that loses arbitration stays pending and is granted after the bus frees up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | N_LVL*N_DEV | Per-device request pulse, bit t*N_DEV+d |
| dev_done | input | N_LVL*N_DEV | Per-device end-of-tenure pulse |
| tier_grant | output | N_LVL | Central grant lines, one per tier |
| dev_master | output | N_LVL*N_DEV | One-hot current bus master |
| bus_busy | output | 1 | High while any device holds the bus |

## Verification
The hardest case to reach is a backlog: pending requests on several tiers and at several chain positions at once, all waiting for one release. In that state, tier order and chain order must both decide the next winner. The directed part of the stimulus builds this case by queueing requests while a master holds the bus. The random part uses long tenures and dense requests so that backlogs form again and again. A bench-side cycle model predicts every output on every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      PRIO_LOW_IDX  = 1'b0,
      PRIO_HIGH_IDX = 1'b1
   } prio_dir_e;
endpackage

// File: rtl/arb_chain_cell.sv
module arb_chain_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic done_i,
   input  logic grant_in,
   output logic grant_out,
   output logic pend_o,
   output logic master_o
);
   logic pend_q;
   logic mast_q;
   logic take;

   assign take      = grant_in & pend_q;
   assign grant_out = grant_in & ~pend_q;
   assign pend_o    = pend_q;
   assign master_o  = mast_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         mast_q <= 1'b0;
      end else begin
         pend_q <= take ? 1'b0 : (pend_q | (req_i & ~mast_q));
         mast_q <= take | (mast_q & ~done_i);
      end
   end
endmodule

// File: rtl/arb_tier_chain.sv
module arb_tier_chain #(
   parameter int N_DEV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_DEV-1:0] req_i,
   input  logic [N_DEV-1:0] done_i,
   input  logic             grant_line,
   output logic             tier_req,
   output logic [N_DEV-1:0] master_o
);
   logic [N_DEV:0]   link;
   logic [N_DEV-1:0] pend;

   assign link[0] = grant_line;

   for (genvar d = 0; d < N_DEV; d++) begin : g_cell
      arb_chain_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_i     (req_i[d]),
         .done_i    (done_i[d]),
         .grant_in  (link[d]),
         .grant_out (link[d+1]),
         .pend_o    (pend[d]),
         .master_o  (master_o[d])
      );
   end

   assign tier_req = |pend;

   logic unused_tail;
   assign unused_tail = link[N_DEV];
endmodule

// File: rtl/arb_tier_picker.sv
module arb_tier_picker #(
   parameter int                N_LVL    = 3,
   parameter arb_pkg::prio_dir_e PRIO_DIR = arb_pkg::PRIO_LOW_IDX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] tier_req,
   input  logic             busy,
   output logic [N_LVL-1:0] grant_o
);
   logic [N_LVL-1:0] sel;
   logic [N_LVL-1:0] grant_q;

   if (PRIO_DIR == arb_pkg::PRIO_LOW_IDX) begin : g_low_first
      always_comb begin
         sel = '0;
         for (int i = N_LVL - 1; i >= 0; i--) begin
            if (tier_req[i]) begin
               sel    = '0;
               sel[i] = 1'b1;
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         sel = '0;
         for (int i = 0; i < N_LVL; i++) begin
            if (tier_req[i]) begin
               sel    = '0;
               sel[i] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
      end else if (grant_q == '0 && !busy && (|tier_req)) begin
         grant_q <= sel;
      end else begin
         grant_q <= '0;
      end
   end

   assign grant_o = grant_q;
endmodule

// File: rtl/prio_chain_arbiter.sv
module prio_chain_arbiter #(
   parameter int                N_LVL    = 3,
   parameter int                N_DEV    = 4,
   parameter arb_pkg::prio_dir_e PRIO_DIR = arb_pkg::PRIO_LOW_IDX
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_LVL*N_DEV-1:0] dev_req,
   input  logic [N_LVL*N_DEV-1:0] dev_done,
   output logic [N_LVL-1:0]       tier_grant,
   output logic [N_LVL*N_DEV-1:0] dev_master,
   output logic                   bus_busy
);
   localparam int N_ALL = N_LVL * N_DEV;

   if (N_LVL < 1) begin : g_bad_lvl
      $error("prio_chain_arbiter: N_LVL must be at least 1");
   end
   if (N_DEV < 1) begin : g_bad_dev
      $error("prio_chain_arbiter: N_DEV must be at least 1");
   end

   logic [N_LVL-1:0] tier_req;
   logic [N_LVL-1:0] grant_w;
   logic [N_ALL-1:0] master_w;

   for (genvar t = 0; t < N_LVL; t++) begin : g_tier
      arb_tier_chain #(.N_DEV(N_DEV)) u_chain (
         .clk        (clk),
         .rst_n      (rst_n),
         .req_i      (dev_req[t*N_DEV +: N_DEV]),
         .done_i     (dev_done[t*N_DEV +: N_DEV]),
         .grant_line (grant_w[t]),
         .tier_req   (tier_req[t]),
         .master_o   (master_w[t*N_DEV +: N_DEV])
      );
   end

   arb_tier_picker #(.N_LVL(N_LVL), .PRIO_DIR(PRIO_DIR)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .tier_req (tier_req),
      .busy     (bus_busy),
      .grant_o  (grant_w)
   );

   assign tier_grant = grant_w;
   assign dev_master = master_w;
   assign bus_busy   = |master_w;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
   parameter int N_LVL = 3,
   parameter int N_DEV = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [N_LVL*N_DEV-1:0] dev_done,
   input logic [N_LVL-1:0]       tier_grant,
   input logic [N_LVL*N_DEV-1:0] dev_master,
   input logic                   bus_busy
);
   assert_one_tier_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tier_grant));

   assert_grant_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tier_grant != '0) |=> (tier_grant == '0) && ($countones(dev_master) == 1));

   assert_single_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_master));

   assert_idle_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tier_grant != '0) |-> !bus_busy);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((dev_master != '0) && ((dev_master & dev_done) == '0)) |=> $stable(dev_master));

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((dev_master & dev_done) != '0) |=> (dev_master == '0) && !bus_busy);
endmodule

bind prio_chain_arbiter arb_checker #(.N_LVL(N_LVL), .N_DEV(N_DEV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dev_done   (dev_done),
   .tier_grant (tier_grant),
   .dev_master (dev_master),
   .bus_busy   (bus_busy)
);

// File: tb/sim_prio_chain_arbiter.sv
module sim_prio_chain_arbiter;
   localparam int NL = 3;
   localparam int ND = 4;
   localparam int NT = NL * ND;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NT-1:0] dev_req = '0;
   logic [NT-1:0] dev_done = '0;
   logic [NL-1:0] tier_grant;
   logic [NT-1:0] dev_master;
   logic          bus_busy;

   int checks = 0;
   int errors = 0;
   bit model_on = 1'b0;

   always #10 clk = ~clk;

   prio_chain_arbiter #(.N_LVL(NL), .N_DEV(ND)) u0 (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_done(dev_done),
      .tier_grant(tier_grant), .dev_master(dev_master), .bus_busy(bus_busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model of the requirements
   logic [NT-1:0] m_pend, m_mast, m_take;
   logic [NL-1:0] m_lg, m_nlg;
   bit            found;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend <= '0;
         m_mast <= '0;
         m_lg   <= '0;
      end else begin
         m_take = '0;
         for (int l = 0; l < NL; l++) begin
            if (m_lg[l]) begin
               found = 1'b0;
               for (int d = 0; d < ND; d++) begin
                  if (!found && m_pend[l*ND+d]) begin
                     m_take[l*ND+d] = 1'b1;
                     found = 1'b1;
                  end
               end
            end
         end
         m_nlg = '0;
         if (m_lg == '0 && m_mast == '0) begin
            found = 1'b0;
            for (int l = 0; l < NL; l++) begin
               if (!found && (|m_pend[l*ND +: ND])) begin
                  m_nlg[l] = 1'b1;
                  found = 1'b1;
               end
            end
         end
         m_mast <= m_take | (m_mast & ~dev_done);
         m_pend <= ~m_take & (m_pend | (dev_req & ~m_mast));
         m_lg   <= m_nlg;
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         chk("R3 tier grant vs model", 32'(tier_grant), 32'(m_lg));
         chk("R4 master vs model", 32'(dev_master), 32'(m_mast));
         chk("R7 busy vs model", 32'(bus_busy), 32'(|m_mast));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_req(input logic [NT-1:0] v);
      dev_req = v;
      cyc(1);
      dev_req = '0;
   endtask

   task automatic pulse_done(input logic [NT-1:0] v);
      dev_done = v;
      cyc(1);
      dev_done = '0;
   endtask

   function automatic logic [NT-1:0] bitv(input int t, input int d);
      logic [NT-1:0] r;
      r = '0;
      r[t*ND+d] = 1'b1;
      return r;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      cyc(2);
      chk("R1 reset tier_grant", 32'(tier_grant), 0);
      chk("R1 reset master", 32'(dev_master), 0);
      chk("R1 reset busy", 32'(bus_busy), 0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 first cycle busy", 32'(bus_busy), 0);
      model_on = 1'b1;

      // R2 timing, single request tier 1 device 2
      pulse_req(bitv(1, 2));
      chk("R2 no grant yet", 32'(tier_grant), 0);
      cyc(1);
      chk("R2 tier grant", 32'(tier_grant), 32'b010);
      cyc(1);
      chk("R2 master", 32'(dev_master), 32'(bitv(1, 2)));
      chk("R5 grant single cycle", 32'(tier_grant), 0);
      chk("R7 busy during tenure", 32'(bus_busy), 1);

      // R6 no grant while busy; R8 master request ignored
      pulse_req(bitv(0, 0));
      pulse_req(bitv(1, 2));
      for (int i = 0; i < 5; i++) begin
         chk("R6 no grant while busy", 32'(tier_grant), 0);
         chk("R6 master held", 32'(dev_master), 32'(bitv(1, 2)));
         cyc(1);
      end
      pulse_done(bitv(1, 2));
      chk("R7 release master", 32'(dev_master), 0);
      chk("R7 release busy", 32'(bus_busy), 0);
      cyc(1);
      chk("R9 waiting request granted", 32'(tier_grant), 32'b001);
      cyc(1);
      chk("R9 waiting device master", 32'(dev_master), 32'(bitv(0, 0)));
      pulse_done(bitv(0, 0));
      cyc(4);
      chk("R8 master request dropped", 32'(tier_grant), 0);
      chk("R8 master request dropped busy", 32'(bus_busy), 0);

      // R3 two tiers at once
      pulse_req(bitv(2, 0) | bitv(1, 3));
      cyc(2);
      chk("R3 lower tier wins", 32'(dev_master), 32'(bitv(1, 3)));
      pulse_done(bitv(1, 3));
      cyc(2);
      chk("R9 other tier served", 32'(dev_master), 32'(bitv(2, 0)));
      pulse_done(bitv(2, 0));

      // R4 same tier, chain order; R8 done from non-master
      pulse_req(bitv(2, 3) | bitv(2, 1));
      cyc(2);
      chk("R4 nearer device wins", 32'(dev_master), 32'(bitv(2, 1)));
      pulse_done(bitv(2, 3));
      chk("R8 stray done ignored", 32'(dev_master), 32'(bitv(2, 1)));
      pulse_done(bitv(2, 1));
      cyc(2);
      chk("R4 farther device later", 32'(dev_master), 32'(bitv(2, 3)));
      pulse_done(bitv(2, 3));

      // backlog across tiers and chain positions
      pulse_req(bitv(0, 3));
      cyc(2);
      pulse_req(bitv(2, 2) | bitv(1, 1) | bitv(1, 0) | bitv(0, 2));
      cyc(3);
      pulse_done(bitv(0, 3));
      cyc(2);
      chk("R3 backlog tier 0 first", 32'(dev_master), 32'(bitv(0, 2)));
      pulse_done(bitv(0, 2));
      cyc(2);
      chk("R4 backlog chain order", 32'(dev_master), 32'(bitv(1, 0)));
      pulse_done(bitv(1, 0));
      cyc(6);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [NT-1:0] r, dn;
         r  = '0;
         dn = '0;
         for (int b = 0; b < NT; b++) begin
            if (($urandom % 10) == 0) r[b] = 1'b1;
         end
         if ((dev_master != '0) && (($urandom % 6) == 0)) dn = dev_master;
         if (($urandom % 20) == 0) dn = dn | r;
         dev_req  = r;
         dev_done = dn;
         cyc(1);
      end
      dev_req = '0;
      for (int n = 0; n < 200; n++) begin
         dev_done = dev_master;
         cyc(1);
      end
      dev_done = '0;
      cyc(2);
      chk("R9 all requests drained", 32'(bus_busy), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule